// File: doc/BRIEF.md
# Mode-Aware Instruction Prefix Decoder

This block sits at the front of an instruction decode path. It accepts one instruction byte per cycle, qualified by a valid strobe, together with a mode code that says how the processor is currently running. It absorbs every prefix byte it sees and stores its effect. When the first non-prefix byte arrives, it emits a one-cycle result with these fields:

- the effective operand and address sizes;
- the four extension bits;
- the surviving segment override;
- the opcode byte;
- a flag for the two vector-extension escape bytes.

Prefix meaning is tied to the mode. Bytes 0x40 to 0x4F are extension prefixes only in the 64-bit mode. In every other mode they are ordinary opcodes. In the 64-bit mode the four classic segment overrides are swallowed without effect, and no 16-bit address size can result. A run of prefixes that reaches the length limit without an opcode raises an error pulse and discards the gathered state.

Top module: `insn_prefix_scan`

## Requirements
- R1: Mode codes are 0 real, 1 virtual-8086, 2 16-bit protected, 3 32-bit protected/compatibility, 4 64-bit; codes 5 to 7 behave as 3. Size codes are 0 = 16 bits, 1 = 32 bits, 2 = 64 bits. With no prefixes, modes 0 to 2 give operand 16 and address 16, modes 3 and 5 to 7 give 32 and 32, and mode 4 gives operand 32 and address 64.
- R2: A 0x66 prefix, once or repeated, turns the operand size to 32 in modes 0 to 2 and to 16 in all other modes.
- R3: A 0x67 prefix, once or repeated, turns the address size to 32 in modes 0 to 2, to 16 in modes 3 and 5 to 7, and to 32 in mode 4. Mode 4 never yields address size 16.
- R4: In mode 4, a byte 0x4X is an extension prefix. Its bits 3, 2, 1, 0 appear on `rex_w`, `rex_r`, `rex_x`, `rex_b`. When W is set, the operand size is 64 even when 0x66 is present.
- R5: In modes other than 4, a byte 0x4X ends the prefix run as the opcode, and all four extension outputs read 0.
- R6: An extension prefix counts only as the last prefix before the opcode. Any legacy prefix after it discards it, and the extension outputs read 0. When two extension prefixes occur back to back, the later one counts.
- R7: Segment overrides are reported on `seg_ovr` as 0 none, 1 for 0x26, 2 for 0x2E, 3 for 0x36, 4 for 0x3E, 5 for 0x64, 6 for 0x65, and the last one present wins. In mode 4, bytes 0x26, 0x2E, 0x36 and 0x3E have no effect.
- R8: `vex_esc` is 1 when the opcode is 0xC4 or 0xC5 and the mode is neither 0 nor 1, and 0 otherwise.
- R9: `out_valid` pulses for exactly one cycle, the cycle after the opcode byte is accepted, with `opcode` equal to that byte. Idle cycles between bytes leave the gathered state unchanged. Each instruction starts from the defaults.
- R10: When the 15th consecutive prefix byte is accepted, `len_err` pulses for one cycle after it, with no `out_valid`, and all gathered prefix state is cleared.
- R11: After reset, `out_valid` and `len_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | `byte_in` holds a byte this cycle |
| byte_in | input | 8 | Instruction byte |
| mode | input | 3 | Processor mode code |
| out_valid | output | 1 | Result fields valid (one-cycle pulse) |
| op_size | output | 2 | Effective operand size code |
| addr_size | output | 2 | Effective address size code |
| rex_w | output | 1 | Extension W bit |
| rex_r | output | 1 | Extension R bit |
| rex_x | output | 1 | Extension X bit |
| rex_b | output | 1 | Extension B bit |
| seg_ovr | output | 3 | Surviving segment override code |
| opcode | output | 8 | First non-prefix byte |
| vex_esc | output | 1 | Vector-extension escape recognised |
| len_err | output | 1 | Prefix run hit the length limit |

## Verification
The properties assume that `mode` holds steady from the first prefix of an instruction through its opcode byte. A mode change partway through a prefix run is outside the contract. The bench therefore picks one mode per instruction, holds it until the result has been sampled, and changes it only between instructions. Idle cycles are inserted at random between bytes, while the mode stays fixed.

// File: rtl/insn_prefix_scan.sv
module insn_prefix_scan #(
  parameter int MAX_LEN = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  input  logic [2:0] mode,
  output logic       out_valid,
  output logic [1:0] op_size,
  output logic [1:0] addr_size,
  output logic       rex_w,
  output logic       rex_r,
  output logic       rex_x,
  output logic       rex_b,
  output logic [2:0] seg_ovr,
  output logic [7:0] opcode,
  output logic       vex_esc,
  output logic       len_err
);
  localparam int CW = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_LEN - 1);
  localparam logic [1:0] SZ16 = 2'd0, SZ32 = 2'd1, SZ64 = 2'd2;

  logic          p66_q, p67_q;
  logic [2:0]    seg_q;
  logic [3:0]    rex_q;
  logic [CW-1:0] cnt_q;

  wire m64 = (mode == 3'd4);
  wire m16 = (mode <= 3'd2);
  wire legacy_rm = (mode <= 3'd1);

  logic [2:0] seg_code;
  always_comb begin
    case (byte_in)
      8'h26:   seg_code = 3'd1;
      8'h2E:   seg_code = 3'd2;
      8'h36:   seg_code = 3'd3;
      8'h3E:   seg_code = 3'd4;
      8'h64:   seg_code = 3'd5;
      8'h65:   seg_code = 3'd6;
      default: seg_code = 3'd0;
    endcase
  end

  wire is_seg    = (seg_code != 3'd0);
  wire is_66     = (byte_in == 8'h66);
  wire is_67     = (byte_in == 8'h67);
  wire is_grp1   = (byte_in == 8'hF0) || (byte_in == 8'hF2) || (byte_in == 8'hF3);
  wire is_rex    = m64 && (byte_in[7:4] == 4'h4);
  wire is_legacy = is_seg || is_66 || is_67 || is_grp1;
  wire is_pfx    = is_legacy || is_rex;
  wire seg_take  = is_seg && !(m64 && seg_code <= 3'd4);

  logic [1:0] op_n, ad_n;
  always_comb begin
    if (m64 && rex_q[3])  op_n = SZ64;
    else if (m16)         op_n = p66_q ? SZ32 : SZ16;
    else                  op_n = p66_q ? SZ16 : SZ32;
    if (m64)              ad_n = p67_q ? SZ32 : SZ64;
    else if (m16)         ad_n = p67_q ? SZ32 : SZ16;
    else                  ad_n = p67_q ? SZ16 : SZ32;
  end

  wire [3:0] rex_out = m64 ? rex_q : 4'b0;
  wire [2:0] seg_out = (m64 && seg_q <= 3'd4) ? 3'd0 : seg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p66_q <= 1'b0; p67_q <= 1'b0; seg_q <= 3'd0; rex_q <= 4'd0; cnt_q <= '0;
      out_valid <= 1'b0; len_err <= 1'b0;
      op_size <= SZ16; addr_size <= SZ16;
      {rex_w, rex_r, rex_x, rex_b} <= 4'b0;
      seg_ovr <= 3'd0; opcode <= 8'h00; vex_esc <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      len_err   <= 1'b0;
      if (byte_valid) begin
        if (is_pfx && cnt_q == LAST) begin
          len_err <= 1'b1;
          p66_q <= 1'b0; p67_q <= 1'b0; seg_q <= 3'd0; rex_q <= 4'd0; cnt_q <= '0;
        end else if (is_pfx) begin
          cnt_q <= cnt_q + 1'b1;
          if (is_66)    p66_q <= 1'b1;
          if (is_67)    p67_q <= 1'b1;
          if (seg_take) seg_q <= seg_code;
          rex_q <= is_rex ? byte_in[3:0] : 4'd0;
        end else begin
          out_valid <= 1'b1;
          op_size   <= op_n;
          addr_size <= ad_n;
          {rex_w, rex_r, rex_x, rex_b} <= rex_out;
          seg_ovr   <= seg_out;
          opcode    <= byte_in;
          vex_esc   <= !legacy_rm && (byte_in == 8'hC4 || byte_in == 8'hC5);
          p66_q <= 1'b0; p67_q <= 1'b0; seg_q <= 3'd0; rex_q <= 4'd0; cnt_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/insn_prefix_scan_chk.sv
module insn_prefix_scan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_valid,
  input logic [7:0] byte_in,
  input logic [2:0] mode,
  input logic       out_valid,
  input logic [1:0] op_size,
  input logic [1:0] addr_size,
  input logic       rex_w,
  input logic       rex_r,
  input logic       rex_x,
  input logic       rex_b,
  input logic [2:0] seg_ovr,
  input logic [7:0] opcode,
  input logic       vex_esc,
  input logic       len_err
);
  assert_no_addr16_in_64_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && mode == 3'd4) |=> !(out_valid && addr_size == 2'd0));

  assert_no_rex_outside_64_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && mode != 3'd4) |=> !(out_valid && (rex_w || rex_r || rex_x || rex_b)));

  assert_seg_filtered_64_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && mode == 3'd4) |=> !(out_valid && seg_ovr != 3'd0 && seg_ovr <= 3'd4));

  assert_no_vex_legacy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && mode <= 3'd1) |=> !(out_valid && vex_esc));

  assert_valid_follows_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(byte_valid));

  assert_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, len_err}));

  assert_err_follows_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> $past(byte_valid));
endmodule

bind insn_prefix_scan insn_prefix_scan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in), .mode(mode),
  .out_valid(out_valid), .op_size(op_size), .addr_size(addr_size),
  .rex_w(rex_w), .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b),
  .seg_ovr(seg_ovr), .opcode(opcode), .vex_esc(vex_esc), .len_err(len_err)
);

// File: tb/insn_prefix_scan_tb.sv
module insn_prefix_scan_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [2:0] mode = 3'd0;
  logic       out_valid, rex_w, rex_r, rex_x, rex_b, vex_esc, len_err;
  logic [1:0] op_size, addr_size;
  logic [2:0] seg_ovr;
  logic [7:0] opcode;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] seq [16];
  int n;

  always #5 clk = ~clk;

  insn_prefix_scan u_dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in), .mode(mode),
    .out_valid(out_valid), .op_size(op_size), .addr_size(addr_size),
    .rex_w(rex_w), .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b),
    .seg_ovr(seg_ovr), .opcode(opcode), .vex_esc(vex_esc), .len_err(len_err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit pfx(input logic [2:0] m, input logic [7:0] b);
    case (b)
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: return 1;
      default: return (m == 3'd4) && (b >= 8'h40 && b <= 8'h4F);
    endcase
  endfunction

  logic [1:0] e_op, e_ad;
  logic [3:0] e_rex;
  logic [2:0] e_seg;
  logic       e_vex;

  task automatic model(input logic [2:0] m);
    bit o = 0, a = 0;
    logic [3:0] rx = 0;
    logic [2:0] sg = 0;
    bit is16 = (m <= 3'd2);
    bit is64 = (m == 3'd4);
    for (int i = 0; i < n - 1; i++) begin
      logic [7:0] b = seq[i];
      if (is64 && b[7:4] == 4'h4) begin
        rx = b[3:0];
        continue;
      end
      rx = 0;
      if (b == 8'h66) o = 1;
      if (b == 8'h67) a = 1;
      if (b == 8'h64) sg = 5;
      if (b == 8'h65) sg = 6;
      if (!is64) begin
        if (b == 8'h26) sg = 1;
        if (b == 8'h2E) sg = 2;
        if (b == 8'h36) sg = 3;
        if (b == 8'h3E) sg = 4;
      end
    end
    e_rex = rx;
    e_seg = sg;
    if (is64) begin
      e_op = rx[3] ? 2'd2 : (o ? 2'd0 : 2'd1);
      e_ad = a ? 2'd1 : 2'd2;
    end else if (is16) begin
      e_op = o ? 2'd1 : 2'd0;
      e_ad = a ? 2'd1 : 2'd0;
    end else begin
      e_op = o ? 2'd0 : 2'd1;
      e_ad = a ? 2'd0 : 2'd1;
    end
    e_vex = (m > 3'd1) && (seq[n-1] == 8'hC4 || seq[n-1] == 8'hC5);
  endtask

  task automatic drive(input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
        byte_valid = 1'b0;
      end
      @(negedge clk);
      byte_valid = 1'b1;
      byte_in = seq[i];
    end
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic run_insn(input logic [2:0] m, input bit gaps, input string tag);
    mode = m;
    model(m);
    drive(gaps);
    check({tag, " R9 out_valid"}, out_valid, 1);
    check({tag, " R9 opcode"}, opcode, seq[n-1]);
    check({tag, " R2/R4 op_size"}, op_size, e_op);
    check({tag, " R3 addr_size"}, addr_size, e_ad);
    check({tag, " R4/R6 rex"}, {rex_w, rex_r, rex_x, rex_b}, e_rex);
    check({tag, " R7 seg_ovr"}, seg_ovr, e_seg);
    check({tag, " R8 vex_esc"}, vex_esc, e_vex);
    check({tag, " R10 len_err"}, len_err, 0);
    @(negedge clk);
    check({tag, " R9 pulse"}, out_valid, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] lst [11] = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
                             8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R11 out_valid reset", out_valid, 0);
    check("R11 len_err reset", len_err, 0);
    rst_n = 1'b1;

    for (int m = 0; m < 8; m++) begin
      n = 1; seq[0] = 8'h90;
      run_insn(3'(m), 0, "R1 default");
    end
    n = 3; seq[0] = 8'h66; seq[1] = 8'h66; seq[2] = 8'h89;
    run_insn(3'd0, 0, "R2 repeat");
    n = 2; seq[0] = 8'h67; seq[1] = 8'h8B;
    run_insn(3'd4, 0, "R3 long");
    n = 3; seq[0] = 8'h66; seq[1] = 8'h48; seq[2] = 8'h01;
    run_insn(3'd4, 0, "R4 w_over_66");
    n = 1; seq[0] = 8'h48;
    run_insn(3'd3, 0, "R5 inc_dec");
    n = 3; seq[0] = 8'h4F; seq[1] = 8'hF3; seq[2] = 8'hA4;
    run_insn(3'd4, 0, "R6 rex_dropped");
    n = 3; seq[0] = 8'h41; seq[1] = 8'h4C; seq[2] = 8'h8B;
    run_insn(3'd4, 0, "R6 last_rex");
    n = 3; seq[0] = 8'h65; seq[1] = 8'h3E; seq[2] = 8'h8B;
    run_insn(3'd4, 0, "R7 long_ignored");
    n = 4; seq[0] = 8'h26; seq[1] = 8'h64; seq[2] = 8'h36; seq[3] = 8'h8B;
    run_insn(3'd3, 0, "R7 last_wins");
    n = 1; seq[0] = 8'hC4;
    run_insn(3'd1, 0, "R8 v86");
    run_insn(3'd2, 0, "R8 prot16");

    mode = 3'd3;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      byte_valid = 1'b1;
      byte_in = 8'h66;
    end
    @(negedge clk);
    byte_valid = 1'b0;
    check("R10 len_err pulse", len_err, 1);
    check("R10 no out_valid", out_valid, 0);
    @(negedge clk);
    check("R10 len_err one cycle", len_err, 0);
    n = 1; seq[0] = 8'h90;
    run_insn(3'd3, 0, "R10 state cleared");

    n = 14;
    for (int i = 0; i < 14; i++) seq[i] = (i == 13) ? 8'hC5 : 8'h67;
    run_insn(3'd2, 1, "R10 fourteen_ok");

    for (int t = 0; t < 400; t++) begin
      logic [2:0] m = 3'($urandom % 8);
      int np = $urandom % 7;
      logic [7:0] op;
      for (int i = 0; i < np; i++) begin
        if (m == 3'd4 && ($urandom % 3 == 0)) seq[i] = 8'h40 | 8'($urandom % 16);
        else seq[i] = lst[$urandom % 11];
      end
      do op = 8'($urandom); while (pfx(m, op));
      seq[np] = op;
      n = np + 1;
      run_insn(m, 1, "rand");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule